// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block runs the external memory cycles of an 8-bit microcontroller core over a narrow multiplexed bus. The core raises a request carrying an address, a code/data flag, an internal/external flag, a read/write flag and write data. The block answers with a one-clock `done` pulse and, for external reads, a captured read byte. On the bus side it drives a multiplexed address/data port with an output enable, a second port for address bytes, an address-latch strobe, a program-store strobe, and separate read and write strobes. All strobes are active high.

Three timing schemes are supported:

- **Non-page mode.** Every external cycle takes four clocks.
- **Page mode.** A cycle whose upper address byte matches the page last latched (a hit) skips the page-address phase. The 2-bit setting `pg_sel` fixes the hit length H, and a miss takes 2H clocks.
- **Code-fast mode.** Code fetches use page timing, but data accesses keep the four-clock layout.

Internal program fetches take one clock and leave the bus quiet.

A cycle occupies the clocks after the edge at which its request is accepted. Clock index 0 is the first clock of the cycle.

Top module: `xbus_seq`

## Requirements
- R1: After reset the block is idle. `done`, `ale`, `psen`, `rd`, `wr` and `bus_ad_oe` are low, `bus_hi` and `bus_ad_o` are zero, and `rdata` is zero.
- R2: A request with `req_ext`=0 is an internal fetch lasting one clock. `done` is high in that clock, no bus strobe is raised, `bus_ad_oe` stays low, and `ale` is high in that clock only if `ale_int_en` was set at acceptance.
- R3: A four-clock cycle runs in this order:
  - Clock 0 drives `addr[7:0]` on `bus_ad_o` with `bus_ad_oe` high.
  - From clock 1 on, `bus_hi` carries `addr[15:8]`.
  - Clocks 2 and 3 form the data phase.
- R4: `pg_sel` sets the hit length H: 0 gives 1, 1 gives 2, and 2 or 3 gives 4. A page-timed hit lasts H clocks and a miss lasts 2H clocks.
  - On a miss, the first H clocks drive `addr[15:8]` on `bus_ad_o` with `bus_ad_oe` high.
  - The remaining H clocks are the data phase, during which `bus_hi` carries `addr[7:0]`.
- R5: A page-timed request is a hit only when its `addr[15:8]` equals the byte latched by the last page-timed cycle. The latched byte is invalidated at reset and whenever `mode` changes between clocks, so the next access after either event is a miss.
- R6: `mode` selects the timing scheme:
  - 0 gives non-page timing for every external cycle.
  - 1 gives page timing for every external cycle.
  - 2 gives page timing for code and four-clock timing for data, and data cycles leave the latched page untouched.
  - 3 behaves as 0.
- R7: `psen` is high exactly in the data phase of external code fetches. `rd` is high exactly in the data phase of external data reads. At most one of `psen`, `rd` and `wr` is high. `req_wr` is ignored when `req_code`=1.
- R8: `ale` is high in clock 0 of every external cycle and low in every other clock of an external cycle.
- R9: During a read data phase `bus_ad_oe` is low. `rdata` takes the value of `bus_ad_i` in the cycle's last clock and holds it from the next clock until the next external read completes.
- R10: During a write data phase `bus_ad_oe` is high and `bus_ad_o` equals the write data. `wr` is high only in the first data-phase clock.
- R11: `done` is high for one clock, the last clock of each cycle. A request is accepted only while idle or in a clock with `done` high, so cycles can follow each other with no gap.
- R12: `mode`, `pg_sel` and `ale_int_en` are sampled only at acceptance. Changing them during a cycle does not alter that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_addr | input | 16 | Request address |
| req_code | input | 1 | 1 = code fetch, 0 = data access |
| req_ext | input | 1 | 1 = external cycle, 0 = internal fetch |
| req_wr | input | 1 | 1 = data write |
| req_wdata | input | 8 | Write data |
| mode | input | 2 | Timing scheme select |
| pg_sel | input | 2 | Page hit/miss length select |
| ale_int_en | input | 1 | Raise `ale` during internal fetches |
| done | output | 1 | Last clock of a cycle |
| rdata | output | 8 | Captured read byte |
| bus_ad_o | output | 8 | Multiplexed address/data out |
| bus_ad_oe | output | 1 | Output enable of the multiplexed port |
| bus_ad_i | input | 8 | Multiplexed port input |
| bus_hi | output | 8 | Address byte port |
| ale | output | 1 | Address-latch strobe |
| psen | output | 1 | Program-store strobe |
| rd | output | 1 | Data read strobe |
| wr | output | 1 | Data write strobe |

## Verification
The stimulus covers the following patterns:

- **Non-page mode.** Code reads, data reads and data writes, with mode 3 aliased to non-page, which checks the four-clock phase order.
- **Page mode.** Each `pg_sel` value is tried with miss-then-hit pairs and page changes, which separates the hit and miss lengths and the address ports of each.
- **Code-fast mode.** Code and data requests are interleaved, which shows data keeping four clocks while code still hits.
- **Invalidation.** A mode round-trip followed by a request to the same page must produce a miss.
- **Timing.** Back-to-back one-clock hits and internal fetches test the acceptance rule. Settings changed during a cycle test sampling at acceptance.

// File: rtl/xbus_seq.sv
module xbus_seq #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2*DW-1:0] req_addr,
  input  logic          req_code,
  input  logic          req_ext,
  input  logic          req_wr,
  input  logic [DW-1:0] req_wdata,
  input  logic [1:0]    mode,
  input  logic [1:0]    pg_sel,
  input  logic          ale_int_en,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] bus_ad_o,
  output logic          bus_ad_oe,
  input  logic [DW-1:0] bus_ad_i,
  output logic [DW-1:0] bus_hi,
  output logic          ale,
  output logic          psen,
  output logic          rd,
  output logic          wr
);
  localparam int AW = 2 * DW;
  localparam int CW = 4;

  logic          busy, c_ext, c_code, c_wr, c_pg, c_miss, c_ale, pg_vld;
  logic [CW-1:0] idx, len, h_q;
  logic [AW-1:0] c_a;
  logic [DW-1:0] c_wd, pg_q, rd_q;
  logic [1:0]    mode_prev;

  logic [CW-1:0] h_n, len_n, ds;
  logic          pg_n, hit_n, acc, xb, dph;

  assign h_n   = (pg_sel == 2'd0) ? CW'(1) : (pg_sel == 2'd1) ? CW'(2) : CW'(4);
  assign pg_n  = req_ext && (mode == 2'd1 || (mode == 2'd2 && req_code));
  assign hit_n = pg_vld && (mode == mode_prev) && (pg_q == req_addr[AW-1:DW]);
  assign len_n = !req_ext ? CW'(1) : !pg_n ? CW'(4) : hit_n ? h_n : (h_n << 1);

  assign done  = busy && (idx == len - CW'(1));
  assign acc   = req_valid && (!busy || done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; idx <= '0; len <= CW'(1); h_q <= CW'(1);
      c_ext <= 1'b0; c_code <= 1'b0; c_wr <= 1'b0; c_pg <= 1'b0;
      c_miss <= 1'b0; c_ale <= 1'b0; c_a <= '0; c_wd <= '0;
    end else if (acc) begin
      busy   <= 1'b1;
      idx    <= '0;
      len    <= len_n;
      h_q    <= h_n;
      c_ext  <= req_ext;
      c_code <= req_code;
      c_wr   <= req_wr && !req_code;
      c_pg   <= pg_n;
      c_miss <= !hit_n;
      c_ale  <= ale_int_en;
      c_a    <= req_addr;
      c_wd   <= req_wdata;
    end else if (done) begin
      busy <= 1'b0;
    end else if (busy) begin
      idx <= idx + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_q <= '0; pg_vld <= 1'b0; mode_prev <= 2'd0; rd_q <= '0;
    end else begin
      mode_prev <= mode;
      if (acc && pg_n) begin
        pg_q   <= req_addr[AW-1:DW];
        pg_vld <= 1'b1;
      end else if (mode != mode_prev) begin
        pg_vld <= 1'b0;
      end
      if (done && c_ext && !c_wr) rd_q <= bus_ad_i;
    end
  end

  assign rdata = rd_q;
  assign ds    = c_pg ? (c_miss ? h_q : '0) : CW'(2);
  assign xb    = busy && c_ext;
  assign dph   = xb && (idx >= ds);
  assign ale   = busy && (c_ext ? (idx == '0) : c_ale);
  assign psen  = dph && c_code;
  assign rd    = dph && !c_code && !c_wr;
  assign wr    = dph && c_wr && (idx == ds);

  always_comb begin
    bus_ad_oe = 1'b0;
    bus_ad_o  = '0;
    if (xb && !c_pg && idx == '0) begin
      bus_ad_oe = 1'b1;
      bus_ad_o  = c_a[DW-1:0];
    end else if (xb && c_pg && c_miss && idx < h_q) begin
      bus_ad_oe = 1'b1;
      bus_ad_o  = c_a[AW-1:DW];
    end else if (dph && c_wr) begin
      bus_ad_oe = 1'b1;
      bus_ad_o  = c_wd;
    end
  end

  always_comb begin
    bus_hi = '0;
    if (xb && !c_pg && idx >= CW'(1)) bus_hi = c_a[AW-1:DW];
    else if (xb && c_pg && idx >= ds) bus_hi = c_a[DW-1:0];
  end

  assert_strobe_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({psen, rd, wr}));

  assert_no_drive_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (psen || rd) |-> !bus_ad_oe);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(psen || rd || wr || bus_ad_oe || done) && bus_hi == '0);

  assert_done_ends_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !acc) |=> !busy && !done);

  assert_cycle_steady_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy && idx == $past(idx) + CW'(1) && len == $past(len)
                        && c_pg == $past(c_pg));
endmodule

// File: tb/xbus_seq_tb_top.sv
`timescale 1ns/1ps
module xbus_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [15:0] req_addr = '0;
  logic        req_code = 1'b0, req_ext = 1'b0, req_wr = 1'b0;
  logic [7:0]  req_wdata = '0;
  logic [1:0]  mode = 2'd0, pg_sel = 2'd0;
  logic        ale_int_en = 1'b0;
  logic        done, ale, psen, rd, wr, bus_ad_oe;
  logic [7:0]  rdata, bus_ad_o, bus_hi;
  logic [7:0]  bus_ad_i = 8'h00;

  xbus_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_code(req_code), .req_ext(req_ext), .req_wr(req_wr), .req_wdata(req_wdata),
    .mode(mode), .pg_sel(pg_sel), .ale_int_en(ale_int_en), .done(done), .rdata(rdata),
    .bus_ad_o(bus_ad_o), .bus_ad_oe(bus_ad_oe), .bus_ad_i(bus_ad_i), .bus_hi(bus_hi),
    .ale(ale), .psen(psen), .rd(rd), .wr(wr));

  always #4 clk = ~clk;

  int    checks = 0, failures = 0, cyc = 0;
  string scen = "R1 reset";

  // expected vector: {rdlast, ale, psen, rd, wr, oe, ad[7:0], hi[7:0], done}
  logic [22:0] q[$];
  logic        m_acc = 1'b0, m_pgv = 1'b0;
  logic [7:0]  m_pg = '0, exp_rd = '0;
  logic [1:0]  m_mprev = 2'd0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s [%s] actual=%0h expected=%0h", tag, scen, act, exp);
    end
  endtask

  task automatic push_cycle(input logic [15:0] a, input logic code, ext, w,
                            input logic [7:0] d, input logic [1:0] md, sel,
                            input logic alen, hit);
    int h, l, ds;
    logic pg, we;
    pg = ext && (md == 2'd1 || (md == 2'd2 && code));
    we = w && !code;
    h  = (sel == 2'd0) ? 1 : (sel == 2'd1) ? 2 : 4;
    l  = !ext ? 1 : !pg ? 4 : hit ? h : 2 * h;
    ds = pg ? (hit ? 0 : h) : 2;
    for (int i = 0; i < l; i++) begin
      logic e_ale, e_ps, e_rd, e_wr, e_oe, dat, e_dn;
      logic [7:0] e_ad, e_hi;
      dat   = ext && i >= ds;
      e_ale = ext ? (i == 0) : alen;
      e_ps  = dat && code;
      e_rd  = dat && !code && !we;
      e_wr  = ext && we && i == ds;
      e_oe  = 1'b0; e_ad = 8'h00; e_hi = 8'h00;
      if (ext && !pg && i == 0) begin e_oe = 1'b1; e_ad = a[7:0]; end
      else if (ext && pg && !hit && i < h) begin e_oe = 1'b1; e_ad = a[15:8]; end
      else if (dat && we) begin e_oe = 1'b1; e_ad = d; end
      if (ext && !pg && i >= 1) e_hi = a[15:8];
      else if (ext && pg && i >= ds) e_hi = a[7:0];
      e_dn = (i == l - 1);
      q.push_back({e_dn && ext && !we, e_ale, e_ps, e_rd, e_wr, e_oe, e_ad, e_hi, e_dn});
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    bus_ad_i <= 8'(cyc) ^ 8'hA5;
    if (cyc == 100000) begin
      failures++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  always @(negedge clk) begin
    logic [22:0] e;
    logic pg, hit;
    if (!rst_n) begin
      q.delete(); m_pgv = 1'b0; m_mprev = 2'd0; m_acc = 1'b0; exp_rd = '0;
      chk("R1 idle", {done, ale, psen, rd, wr, bus_ad_oe}, 0);
      chk("R1 ports", {bus_hi, bus_ad_o, rdata}, 0);
    end else begin
      e = (q.size() != 0) ? q[0] : '0;
      chk("R8 ale", ale, e[21]);
      chk("R7 psen", psen, e[20]);
      chk("R7 rd", rd, e[19]);
      chk("R10 wr", wr, e[18]);
      chk("R3 oe", bus_ad_oe, e[17]);
      chk("R3 ad", bus_ad_o, e[16:9]);
      chk("R4 hi", bus_hi, e[8:1]);
      chk("R11 done", done, e[0]);
      chk("R9 rdata", rdata, exp_rd);
      if (q.size() != 0) begin
        if (e[22]) exp_rd = bus_ad_i;
        void'(q.pop_front());
      end
      m_acc = req_valid && q.size() == 0;
      pg  = req_ext && (mode == 2'd1 || (mode == 2'd2 && req_code));
      hit = pg && m_pgv && mode == m_mprev && m_pg == req_addr[15:8];
      if (m_acc)
        push_cycle(req_addr, req_code, req_ext, req_wr, req_wdata, mode, pg_sel, ale_int_en, hit);
      if (m_acc && pg) begin m_pg = req_addr[15:8]; m_pgv = 1'b1; end
      else if (mode != m_mprev) m_pgv = 1'b0;
      m_mprev = mode;
    end
  end

  task automatic go(input logic [15:0] a, input logic code, ext, w, input logic [7:0] d);
    req_addr = a; req_code = code; req_ext = ext; req_wr = w; req_wdata = d;
    req_valid = 1'b1;
    do @(posedge clk); while (!m_acc);
    #1 req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(2);

    scen = "R2 internal fetch";
    go(16'h0100, 1, 0, 0, 8'h00); go(16'h0101, 1, 0, 0, 8'h00);
    ale_int_en = 1'b1; go(16'h0102, 1, 0, 0, 8'h00); go(16'h0103, 1, 0, 0, 8'h00);
    ale_int_en = 1'b0; idle(2);

    scen = "R3 R9 R10 nonpage";
    mode = 2'd0;
    go(16'h12A4, 1, 1, 0, 8'h00); go(16'h3456, 0, 1, 0, 8'h00);
    go(16'h789A, 0, 1, 1, 8'hC3); idle(1);
    go(16'h789A, 0, 1, 0, 8'h00); idle(3);
    scen = "R6 mode3 as nonpage";
    mode = 2'd3; go(16'h4411, 1, 1, 0, 8'h00); go(16'h4412, 1, 1, 0, 8'h00); idle(3);

    scen = "R4 R5 page timing";
    mode = 2'd1;
    for (int s = 0; s < 4; s++) begin
      pg_sel = 2'(s);
      go(16'h2000 + 16'(s << 8), 1, 1, 0, 8'h00);
      go(16'h2010 + 16'(s << 8), 1, 1, 0, 8'h00);
      go(16'h2020 + 16'(s << 8), 0, 1, 1, 8'h5A);
      go(16'h2030 + 16'(s << 8), 0, 1, 0, 8'h00);
      go(16'h6000, 0, 1, 1, 8'hE7);
      idle(2);
    end

    scen = "R5 mode change invalidates";
    pg_sel = 2'd1; go(16'h5500, 1, 1, 0, 8'h00); idle(1);
    mode = 2'd0; idle(1); mode = 2'd1; idle(1);
    go(16'h5501, 1, 1, 0, 8'h00); go(16'h5502, 1, 1, 0, 8'h00); idle(3);

    scen = "R6 code-fast mode";
    mode = 2'd2; pg_sel = 2'd0; idle(1);
    go(16'h7700, 1, 1, 0, 8'h00); go(16'h7701, 1, 1, 0, 8'h00);
    go(16'h1234, 0, 1, 0, 8'h00); go(16'h7702, 1, 1, 0, 8'h00);
    go(16'h9999, 0, 1, 1, 8'h81); go(16'h7703, 1, 1, 0, 8'h00); idle(3);

    scen = "R7 code ignores write flag";
    go(16'h7704, 1, 1, 1, 8'hFF); mode = 2'd0; idle(1);
    go(16'h3333, 1, 1, 1, 8'hFF); idle(5);

    scen = "R11 back-to-back hits";
    mode = 2'd1; pg_sel = 2'd0; idle(1);
    for (int i = 0; i < 6; i++) go(16'hAB00 + 16'(i), 0, 1, i[0], 8'(i * 17));
    go(16'h0000, 1, 0, 0, 8'h00); go(16'hAB07, 1, 1, 0, 8'h00); idle(3);

    scen = "R12 mid-cycle settings";
    pg_sel = 2'd2; go(16'hCD00, 1, 1, 0, 8'h00);
    pg_sel = 2'd0; mode = 2'd0; ale_int_en = 1'b1; idle(10);
    mode = 2'd2; go(16'hCD10, 0, 1, 0, 8'h00); mode = 2'd1; idle(6);
    go(16'h0002, 1, 0, 0, 8'h00); ale_int_en = 1'b0; idle(4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule